// File: doc/BRIEF.md
# Double-Precision Truncate-to-Integral Unit

This unit takes a 128-bit vector-scalar source operand. It reads the binary64 floating-point value in the low doubleword, which is bits [63:0], and cuts it to an integral value by dropping every fraction bit. The operation always rounds toward zero, so the magnitude of the value can only stay the same or shrink. The unit writes a 128-bit result whose upper half is always zero. It also reports updates for a small group of floating-point status fields:

- a 5-bit result class code
- a sticky exception summary
- an invalid-operation flag for signaling NaN inputs
- the fraction-rounded and fraction-inexact bits, which are always cleared

The surrounding pipeline presents one operation per `in_valid` strobe. It also supplies a unit-enable bit and the invalid-operation exception enable. Every result and status output appears exactly one clock after the strobe. When the unit is disabled, the unit only raises a one-cycle unavailable-trap pulse. The register file, the status register and trap handling live outside this unit. The unit drives only the write strobes and the values that go to them.

Top module: `fp64_trunc_unit`

## Requirements
- R1: For a finite operand whose unbiased exponent lies between 0 and 51, the result in bits [63:0] is the operand with every bit below the binary point cleared, keeping the sign. For example, 2.75 becomes 2.0 and -2.75 becomes -2.0.
- R2: The following operands are returned unchanged: those with an unbiased exponent of 52 or more, infinities, and quiet NaNs (exponent all ones, fraction bit 51 set).
- R3: Zeros and nonzero operands with magnitude below 1 (denormals included) give a zero that carries the operand's sign bit 63.
- R4: `out_result[127:64]` is always zero, and `src_opnd[127:64]` has no effect on any output.
- R5: All result and status outputs are valid exactly one clock after `in_valid`. In a cycle that does not follow a strobe, all outputs are zero.
- R6: An operation issued with `unit_en`=0 gives `out_unavail_trap`=1 for one cycle. It gives no write, no class write and no status update, and all other outputs are zero.
- R7: A signaling NaN (exponent all ones, fraction nonzero, bit 51 clear) sets both `out_vxsnan_set` and `out_fx_set`. When `inv_exc_en`=0, the result is that NaN with bit 51 set.
- R8: A signaling NaN with `inv_exc_en`=1 suppresses `out_wr_en` and `out_class_wr`, and forces `out_result` and `out_class` to zero. `out_stat_valid`, `out_vxsnan_set` and `out_fx_set` are still asserted.
- R9: When `out_class_wr`=1, `out_class` classifies the written result using these codes:

  | Result class | Code |
  |---|---|
  | +normal | 00100 |
  | -normal | 01000 |
  | +zero | 00010 |
  | -zero | 10010 |
  | +infinity | 00101 |
  | -infinity | 01001 |
  | NaN | 10001 |
  | +denormal | 10100 |
  | -denormal | 11000 |

  When `out_class_wr`=0, `out_class` is zero.
- R10: Whenever `out_stat_valid`=1, the values `out_fr` and `out_fi` are 0, including when the write is suppressed.
- R11: While `rst_n` is low at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src_opnd | input | 128 | Source operand; binary64 value in [63:0] |
| unit_en | input | 1 | Unit enable; 0 raises the unavailable trap |
| inv_exc_en | input | 1 | Invalid-operation exception enable |
| out_wr_en | output | 1 | Target register write strobe |
| out_result | output | 128 | Value to write; [127:64] always zero |
| out_stat_valid | output | 1 | Status fields update this cycle |
| out_class_wr | output | 1 | Result class field write strobe |
| out_class | output | 5 | Result class code |
| out_fx_set | output | 1 | Set sticky exception summary |
| out_vxsnan_set | output | 1 | Set signaling-NaN invalid flag |
| out_fr | output | 1 | Fraction-rounded value to store |
| out_fi | output | 1 | Fraction-inexact value to store |
| out_unavail_trap | output | 1 | Unit-unavailable trap pulse |

## Verification
The patterns cover four groups, and each separates a different part of the function:

- Values with fractional parts at mixed exponents, both signs, are checked alongside the two limits. One limit is the largest value that still has a single fraction bit; the other is the smallest exponent with no fraction bits. Together these show where the clearing mask starts and stops.
- Values below one, denormals and signed zeros separate the signed-zero path from the masking path.
- Infinities, quiet NaNs and signaling NaNs under both exception-enable settings separate quieting from write suppression.
- Disabled-unit issues, back-to-back issues and junk in the upper source half show that the trap, the timing and the upper half behave independently of the arithmetic.

// File: rtl/fp64_trunc_pkg.sv
// Package: shared field widths and result class codes for the truncate unit.
// Assumes IEEE-754 binary64 layout: sign, 11-bit exponent, 52-bit fraction.
package fp64_trunc_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int CLS_W  = 5;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE     = 5'b00000,
        CLS_POS_NORM = 5'b00100,
        CLS_NEG_NORM = 5'b01000,
        CLS_POS_ZERO = 5'b00010,
        CLS_NEG_ZERO = 5'b10010,
        CLS_POS_INF  = 5'b00101,
        CLS_NEG_INF  = 5'b01001,
        CLS_QNAN     = 5'b10001,
        CLS_POS_DEN  = 5'b10100,
        CLS_NEG_DEN  = 5'b11000
    } fp_class_e;
endpackage

// File: rtl/fp64_trunc_core.sv
// Module: fp64_trunc_core
// Combinational truncation of one binary floating-point value toward zero.
// Assumes exponent bias 2^(EXPW-1)-1. Signaling NaNs are quieted by setting
// the fraction MSB; values below one collapse to a signed zero.
module fp64_trunc_core #(
    parameter int EXPW  = 11,
    parameter int FRACW = 52
) (
    input  logic [EXPW+FRACW:0] op_in,
    output logic [EXPW+FRACW:0] res_out,
    output logic                snan_out
);
    localparam int TOPB = EXPW + FRACW;
    localparam logic [EXPW-1:0] EXP_ONES = '1;
    localparam logic [EXPW-1:0] BIAS_V   = {1'b0, {(EXPW-1){1'b1}}};
    localparam logic [EXPW:0]   LIMIT    = {1'b0, BIAS_V} + (EXPW+1)'(FRACW);

    logic             sgn;
    logic [EXPW-1:0]  ex;
    logic [FRACW-1:0] fr;
    logic [FRACW-1:0] clr_mask;

    assign sgn = op_in[TOPB];
    assign ex  = op_in[TOPB-1:FRACW];
    assign fr  = op_in[FRACW-1:0];

    // Per-bit mask: fraction bit i lies below the binary point when ex+i < LIMIT.
    for (genvar i = 0; i < FRACW; i++) begin : g_mask
        assign clr_mask[i] = (({1'b0, ex} + (EXPW+1)'(i)) < LIMIT);
    end

    // Select the truncated value by operand category.
    always_comb begin
        res_out  = op_in;
        snan_out = 1'b0;
        if (ex == EXP_ONES) begin
            if ((fr != '0) && !fr[FRACW-1]) begin
                snan_out = 1'b1;
                res_out  = {sgn, ex, 1'b1, fr[FRACW-2:0]};
            end
        end else if (ex < BIAS_V) begin
            res_out = {sgn, {TOPB{1'b0}}};
        end else if ({1'b0, ex} < LIMIT) begin
            res_out = {sgn, ex, fr & ~clr_mask};
        end
    end
endmodule

// File: rtl/fp64_classify.sv
// Module: fp64_classify
// Maps a binary floating-point value to its 5-bit result class code.
// Assumes any NaN presented here is already quiet.
module fp64_classify
    import fp64_trunc_pkg::*;
#(
    parameter int EXPW  = 11,
    parameter int FRACW = 52
) (
    input  logic [EXPW+FRACW:0] val_in,
    output logic [CLS_W-1:0]    cls_out
);
    localparam int TOPB = EXPW + FRACW;

    logic             sgn;
    logic [EXPW-1:0]  ex;
    logic [FRACW-1:0] fr;

    assign sgn = val_in[TOPB];
    assign ex  = val_in[TOPB-1:FRACW];
    assign fr  = val_in[FRACW-1:0];

    // Decode exponent and fraction into the class code.
    always_comb begin
        if (ex == '1) begin
            if (fr != '0) cls_out = CLS_QNAN;
            else          cls_out = sgn ? CLS_NEG_INF : CLS_POS_INF;
        end else if (ex == '0) begin
            if (fr == '0) cls_out = sgn ? CLS_NEG_ZERO : CLS_POS_ZERO;
            else          cls_out = sgn ? CLS_NEG_DEN : CLS_POS_DEN;
        end else begin
            cls_out = sgn ? CLS_NEG_NORM : CLS_POS_NORM;
        end
    end
endmodule

// File: rtl/fp64_trunc_unit.sv
// Module: fp64_trunc_unit (top)
// One-stage truncate-to-integral unit: computes combinationally, registers
// all outputs one clock after in_valid. Assumes OPW = 2 * binary64 width.
module fp64_trunc_unit
    import fp64_trunc_pkg::*;
#(
    parameter int OPW = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OPW-1:0]   src_opnd,
    input  logic             unit_en,
    input  logic             inv_exc_en,
    output logic             out_wr_en,
    output logic [OPW-1:0]   out_result,
    output logic             out_stat_valid,
    output logic             out_class_wr,
    output logic [CLS_W-1:0] out_class,
    output logic             out_fx_set,
    output logic             out_vxsnan_set,
    output logic             out_fr,
    output logic             out_fi,
    output logic             out_unavail_trap
);
    localparam int HALF = OPW / 2;

    logic [FP_W-1:0]  trunc_val;
    logic             is_snan;
    logic [CLS_W-1:0] cls_comb;
    logic             go;
    logic             do_write;

    logic [FP_W-1:0]  res_q;
    logic             wr_q, stat_q, cls_wr_q, vx_q, trap_q;
    logic [CLS_W-1:0] cls_q;

    fp64_trunc_core #(.EXPW(EXP_W), .FRACW(FRAC_W)) u_core (
        .op_in    (src_opnd[FP_W-1:0]),
        .res_out  (trunc_val),
        .snan_out (is_snan)
    );

    fp64_classify #(.EXPW(EXP_W), .FRACW(FRAC_W)) u_cls (
        .val_in  (trunc_val),
        .cls_out (cls_comb)
    );

    // Issue qualification and write-suppression decision.
    assign go       = in_valid && unit_en;
    assign do_write = go && !(is_snan && inv_exc_en);

    // Output stage register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            res_q    <= '0;
            stat_q   <= 1'b0;
            cls_wr_q <= 1'b0;
            cls_q    <= '0;
            vx_q     <= 1'b0;
            trap_q   <= 1'b0;
        end else begin
            wr_q     <= do_write;
            res_q    <= do_write ? trunc_val : '0;
            stat_q   <= go;
            cls_wr_q <= do_write;
            cls_q    <= do_write ? cls_comb : '0;
            vx_q     <= go && is_snan;
            trap_q   <= in_valid && !unit_en;
        end
    end

    assign out_wr_en        = wr_q;
    assign out_result       = {{(OPW-HALF){1'b0}}, {(HALF-FP_W){1'b0}}, res_q};
    assign out_stat_valid   = stat_q;
    assign out_class_wr     = cls_wr_q;
    assign out_class        = cls_q;
    assign out_fx_set       = vx_q;
    assign out_vxsnan_set   = vx_q;
    assign out_fr           = 1'b0;
    assign out_fi           = 1'b0;
    assign out_unavail_trap = trap_q;
endmodule

// File: rtl/fp64_trunc_chk.sv
// Module: fp64_trunc_chk
// Property checker for fp64_trunc_unit, attached by bind below.
// Assumes the default 128-bit operand width.
module fp64_trunc_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [127:0] src_opnd,
    input logic         unit_en,
    input logic         inv_exc_en,
    input logic         out_wr_en,
    input logic [127:0] out_result,
    input logic         out_stat_valid,
    input logic         out_class_wr,
    input logic [4:0]   out_class,
    input logic         out_fx_set,
    input logic         out_vxsnan_set,
    input logic         out_fr,
    input logic         out_fi,
    input logic         out_unavail_trap
);
    logic past_ok;

    // Tracks whether a full reset-free cycle has elapsed, so $past is meaningful.
    always_ff @(posedge clk) past_ok <= rst_n;

    p_wr_timing_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        out_stat_valid |-> $past(in_valid && unit_en));

    p_trap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        out_unavail_trap |-> ($past(in_valid && !unit_en) && !out_stat_valid && !out_wr_en));

    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_result[127:64] == 64'd0);

    p_no_growth_r1: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (out_wr_en && out_class != 5'b10001) |-> (out_result[62:0] <= $past(src_opnd[62:0])));

    p_sign_kept_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        out_wr_en |-> (out_result[63] == $past(src_opnd[63])));

    p_snan_suppress_r8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (out_vxsnan_set && $past(inv_exc_en)) |-> (!out_wr_en && !out_class_wr && out_stat_valid));

    p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_stat_valid |-> (!out_fr && !out_fi));
endmodule

bind fp64_trunc_unit fp64_trunc_chk u_chk (.*);

// File: tb/tb_fp64_trunc_unit.sv
module tb_fp64_trunc_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_opnd = '0;
    logic         unit_en = 1'b0;
    logic         inv_exc_en = 1'b0;
    logic         out_wr_en, out_stat_valid, out_class_wr, out_fx_set;
    logic         out_vxsnan_set, out_fr, out_fi, out_unavail_trap;
    logic [127:0] out_result;
    logic [4:0]   out_class;

    int checks = 0;
    int fails  = 0;
    logic sampled_valid = 1'b0;
    logic done = 1'b0;

    typedef struct {
        logic         trap, wr, stat, cwr, vx;
        logic [4:0]   cls;
        logic [127:0] res;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    fp64_trunc_unit dut (.*);

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Driver: presents one operation and queues its expected outcome.
    task automatic issue(input logic [63:0] val, input logic en, input logic ve,
                         input logic [63:0] hi, input logic [63:0] eres,
                         input logic [4:0] ecls, input logic snan, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid   = 1'b1;
        src_opnd   = {hi, val};
        unit_en    = en;
        inv_exc_en = ve;
        e.trap = !en;
        e.stat = en;
        e.wr   = en && !(snan && ve);
        e.cwr  = e.wr;
        e.vx   = en && snan;
        e.cls  = e.cwr ? ecls : 5'd0;
        e.res  = e.wr ? {64'd0, eres} : 128'd0;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0;
        src_opnd = {2{64'hDEAD_BEEF_0BAD_F00D}};
    endtask

    always @(posedge clk) sampled_valid <= in_valid && rst_n;

    // Monitor: compares outputs against the scoreboard after each issue cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sampled_valid) begin
                exp_t e;
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R5 output with empty scoreboard actual=1 expected=0");
                end else begin
                    e = sb.pop_front();
                    chk({e.tag, " result"}, out_result, e.res);
                    chk({e.tag, " class"}, {123'd0, out_class}, {123'd0, e.cls});
                    chk({e.tag, " strobes wr/cwr/stat/trap"},
                        {124'd0, out_wr_en, out_class_wr, out_stat_valid, out_unavail_trap},
                        {124'd0, e.wr, e.cwr, e.stat, e.trap});
                    chk({e.tag, " vxsnan/fx"}, {126'd0, out_vxsnan_set, out_fx_set},
                        {126'd0, e.vx, e.vx});
                    chk({e.tag, " R10 fr/fi"}, {126'd0, out_fr, out_fi}, 128'd0);
                end
            end else begin
                chk("R5 idle outputs zero",
                    out_result | {117'd0, out_wr_en, out_stat_valid, out_class_wr, out_class,
                                  out_fx_set, out_vxsnan_set, out_unavail_trap}, 128'd0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset outputs",
            out_result | {117'd0, out_wr_en, out_stat_valid, out_class_wr, out_class,
                          out_fx_set, out_vxsnan_set, out_unavail_trap}, 128'd0);
        rst_n = 1'b1;
        idle_in();
        idle_in();

        issue(64'h4006000000000000, 1, 0, 0, 64'h4000000000000000, 5'b00100, 0, "R1 2.75");
        issue(64'hC006000000000000, 1, 0, 0, 64'hC000000000000000, 5'b01000, 0, "R1 -2.75");
        issue(64'h3FF8000000000000, 1, 0, 0, 64'h3FF0000000000000, 5'b00100, 0, "R1 1.5");
        issue(64'h405EDD2F1A9FBE77, 1, 0, 0, 64'h405EC00000000000, 5'b00100, 0, "R1 123.456");
        issue(64'h432FFFFFFFFFFFFF, 1, 0, 0, 64'h432FFFFFFFFFFFFE, 5'b00100, 0, "R1 exp51 edge");
        idle_in();
        issue(64'h4330000000000000, 1, 0, 0, 64'h4330000000000000, 5'b00100, 0, "R2 exp52");
        issue(64'h7E37E43C8800759C, 1, 0, 0, 64'h7E37E43C8800759C, 5'b00100, 0, "R2 huge");
        issue(64'h7FF0000000000000, 1, 0, 0, 64'h7FF0000000000000, 5'b00101, 0, "R2 R9 +inf");
        issue(64'hFFF0000000000000, 1, 0, 0, 64'hFFF0000000000000, 5'b01001, 0, "R2 R9 -inf");
        issue(64'h7FF8000000000001, 1, 1, 0, 64'h7FF8000000000001, 5'b10001, 0, "R2 qnan");
        idle_in();
        issue(64'h3FE0000000000000, 1, 0, 0, 64'h0000000000000000, 5'b00010, 0, "R3 0.5");
        issue(64'hBFD0000000000000, 1, 0, 0, 64'h8000000000000000, 5'b10010, 0, "R3 -0.25");
        issue(64'h0000000000000001, 1, 0, 0, 64'h0000000000000000, 5'b00010, 0, "R3 +denorm");
        issue(64'h8000000000000001, 1, 0, 0, 64'h8000000000000000, 5'b10010, 0, "R3 -denorm");
        issue(64'h8000000000000000, 1, 0, 0, 64'h8000000000000000, 5'b10010, 0, "R3 -zero");
        idle_in();
        issue(64'hC006000000000000, 1, 0, 64'hFFFFFFFFFFFFFFFF, 64'hC000000000000000, 5'b01000, 0, "R4 upper junk");
        issue(64'h3FF8000000000000, 0, 0, 0, 64'h0, 5'b0, 0, "R6 disabled");
        issue(64'h7FF0000000000001, 0, 1, 0, 64'h0, 5'b0, 1, "R6 disabled snan");
        idle_in();
        issue(64'h7FF0000000000001, 1, 0, 0, 64'h7FF8000000000001, 5'b10001, 1, "R7 snan");
        issue(64'hFFF4000000000000, 1, 0, 64'h1234, 64'hFFFC000000000000, 5'b10001, 1, "R7 -snan");
        issue(64'h7FF0000000000001, 1, 1, 0, 64'h0, 5'b0, 1, "R8 snan trap-enabled");
        issue(64'h4006000000000000, 1, 1, 0, 64'h4000000000000000, 5'b00100, 0, "R8 ve only");
        idle_in();
        idle_in();
        idle_in();

        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R5 pending results actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule